// File: doc/BRIEF.md
# Nine-Bit Address-Filtering Serial Receiver with Reply Transmitter

This block is the serial port of one slave on a shared asynchronous line. A single master addresses many slaves. Every frame carries nine payload bits, and the ninth bit says what the low eight bits hold. When the ninth bit is 1 they are a select code, and when it is 0 they are plain data. A slave keeps a wake-up flag. While the flag is set, the slave listens only for select codes. When a select code equals the slave's own code, the hardware clears the flag, and the data frames that follow are then handed to the host. Because this filter works in hardware, a slave that was not addressed takes no interrupt for traffic meant for another slave.

The line is sampled on an oversample tick supplied from outside. By default the tick runs at sixteen times the bit rate. A short transmitter in the same block lets an addressed slave answer the master. Every reply frame goes out with its ninth bit at 0. Software can set the flag again at any time with a one-cycle re-arm strobe.

Top module: `mwu_node`

## Requirements
- R1: A received frame is a low start bit, then 8 data bits with the least significant bit first, then the ninth bit, then a high stop bit. Each bit is sampled at its middle. A delivered frame shows its 8 data bits on rx_data_o and its ninth bit on rx_bit9_o.
- R2: After reset, wake_o is 1, rx_irq_o and frame_err_o are 0, tx_busy_o is 0 and txd_o is 1.
- R3: While wake_o is 1, a frame whose ninth bit is 0 raises no rx_irq_o.
- R4: A frame whose ninth bit is 1 and whose data equals own_code_i clears wake_o to 0. It raises rx_irq_o with rx_bit9_o = 1 and rx_data_o equal to the code.
- R5: While wake_o is 0, a frame whose ninth bit is 0 raises rx_irq_o with rx_bit9_o = 0 and the received byte.
- R6: A frame whose ninth bit is 1 and whose data differs from own_code_i sets wake_o to 1 and raises no rx_irq_o.
- R7: A matching address frame that arrives while wake_o is 0 leaves wake_o at 0 and raises rx_irq_o.
- R8: A stop bit sampled low pulses frame_err_o for one cycle, raises no rx_irq_o and leaves wake_o unchanged. The receiver then waits for the line to go high before it looks for a new start bit.
- R9: A low pulse that has ended by the middle of the start bit is not taken as a frame. The frame after it is received correctly.
- R10: rearm_i held high for one cycle makes wake_o 1 on the next cycle.
- R11: A tx_start_i pulse while the transmitter is idle sends tx_data_i as a frame on txd_o: start bit, data with the least significant bit first, a ninth bit of 0, then a stop bit. tx_busy_o stays high from the start bit to the end of the stop bit.
- R12: A tx_start_i pulse while tx_busy_o is high is ignored.
- R13: rx_irq_o and frame_err_o are single-cycle pulses, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversample tick, OVS ticks per bit |
| rxd_i | input | 1 | Serial receive line, idles high |
| own_code_i | input | DATA_W | Select code of this slave |
| rearm_i | input | 1 | One-cycle strobe that sets the wake-up flag |
| rx_data_o | output | DATA_W | Byte of the last delivered frame |
| rx_bit9_o | output | 1 | Ninth bit of the last delivered frame |
| rx_irq_o | output | 1 | Pulse for each delivered frame |
| frame_err_o | output | 1 | Pulse for a frame whose stop bit was low |
| wake_o | output | 1 | Wake-up flag (1 means only select codes are accepted) |
| tx_data_i | input | DATA_W | Byte to send as a reply |
| tx_start_i | input | 1 | Starts a reply when the transmitter is idle |
| tx_busy_o | output | 1 | High while a reply frame is on the line |
| txd_o | output | 1 | Serial transmit line, idles high |

## Verification
The receiver gets a random mix of address and data frames. Addresses are chosen half the time equal to the own code and otherwise random. About one frame in eight has a bad stop bit, and re-arm strobes are placed between frames. This mix separates the four cases of the filter: armed data, disarmed data, matching address and mismatching address. It also shows whether a framing error disturbs the flag. Directed frames cover matching and mismatching addresses while already disarmed, and a start glitch too short to be a frame. A loopback from the transmitter into the receiver checks the bit order of replies, the forced ninth bit, the busy window and a start request made during a busy frame.

// File: rtl/mwu_pkg.sv
package mwu_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_BITS,
      RX_STOP,
      RX_BREAK
   } rx_state_e;

   typedef enum logic {
      TX_IDLE,
      TX_SEND
   } tx_state_e;

endpackage

// File: rtl/mwu_rx_deframe.sv
module mwu_rx_deframe
   import mwu_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              stop_ok_o
);

   localparam int unsigned CNT_W      = $clog2(OVS);
   localparam int unsigned FRAME_BITS = DATA_W + 1;
   localparam int unsigned IDX_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] MID   = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_BITS - 1);

   logic rx_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rxd_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '1;
            end else begin
               sync_q[0] <= rxd_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sync_q[i] <= sync_q[i-1];
               end
            end
         end
         assign rx_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_e             st_q;
   logic [CNT_W-1:0]      cnt_q;
   logic [IDX_W-1:0]      idx_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic                  done_q;
   logic                  stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         sh_q   <= '0;
         done_q <= 1'b0;
         stop_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick_i) begin
            unique case (st_q)
               RX_IDLE: begin
                  if (!rx_s) begin
                     st_q  <= RX_START;
                     cnt_q <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == MID) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     st_q  <= rx_s ? RX_IDLE : RX_BITS;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (cnt_q == LAST) begin
                     cnt_q <= '0;
                     sh_q  <= {rx_s, sh_q[FRAME_BITS-1:1]};
                     if (idx_q == IDX_END) begin
                        st_q <= RX_STOP;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == LAST) begin
                     cnt_q  <= '0;
                     done_q <= 1'b1;
                     stop_q <= rx_s;
                     st_q   <= rx_s ? RX_IDLE : RX_BREAK;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_BREAK: begin
                  if (rx_s) begin
                     st_q <= RX_IDLE;
                  end
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign done_o    = done_q;
   assign data_o    = sh_q[DATA_W-1:0];
   assign bit9_o    = sh_q[FRAME_BITS-1];
   assign stop_ok_o = stop_q;

endmodule

// File: rtl/mwu_wake_filter.sv
module mwu_wake_filter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              bit9_i,
   input  logic              stop_ok_i,
   input  logic [DATA_W-1:0] own_i,
   input  logic              rearm_i,
   output logic              wake_o,
   output logic              irq_o,
   output logic              ferr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o
);

   logic              wake_q;
   logic              irq_q;
   logic              ferr_q;
   logic [DATA_W-1:0] data_q;
   logic              bit9_q;
   logic              hit;

   assign hit = (data_i == own_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b1;
         irq_q  <= 1'b0;
         ferr_q <= 1'b0;
         data_q <= '0;
         bit9_q <= 1'b0;
      end else begin
         irq_q  <= 1'b0;
         ferr_q <= 1'b0;
         if (done_i) begin
            if (!stop_ok_i) begin
               ferr_q <= 1'b1;
            end else if (bit9_i) begin
               if (hit) begin
                  wake_q <= 1'b0;
                  irq_q  <= 1'b1;
                  data_q <= data_i;
                  bit9_q <= 1'b1;
               end else begin
                  wake_q <= 1'b1;
               end
            end else if (!wake_q) begin
               irq_q  <= 1'b1;
               data_q <= data_i;
               bit9_q <= 1'b0;
            end
         end
         if (rearm_i) begin
            wake_q <= 1'b1;
         end
      end
   end

   assign wake_o = wake_q;
   assign irq_o  = irq_q;
   assign ferr_o = ferr_q;
   assign data_o = data_q;
   assign bit9_o = bit9_q;

endmodule

// File: rtl/mwu_tx.sv
module mwu_tx
   import mwu_pkg::*;
#(
   parameter int unsigned OVS    = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              start_i,
   output logic              busy_o,
   output logic              txd_o
);

   localparam int unsigned CNT_W   = $clog2(OVS);
   localparam int unsigned FRAME_W = DATA_W + 3;
   localparam int unsigned BIDX_W  = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0]  LAST     = CNT_W'(OVS - 1);
   localparam logic [BIDX_W-1:0] BIDX_END = BIDX_W'(FRAME_W - 1);

   tx_state_e          st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [BIDX_W-1:0]  bidx_q;
   logic [FRAME_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TX_IDLE;
         cnt_q  <= '0;
         bidx_q <= '0;
         sh_q   <= '1;
      end else begin
         unique case (st_q)
            TX_IDLE: begin
               if (start_i) begin
                  st_q   <= TX_SEND;
                  cnt_q  <= '0;
                  bidx_q <= '0;
                  sh_q   <= {1'b1, 1'b0, data_i, 1'b0};
               end
            end
            TX_SEND: begin
               if (tick_i) begin
                  if (cnt_q == LAST) begin
                     cnt_q <= '0;
                     if (bidx_q == BIDX_END) begin
                        st_q <= TX_IDLE;
                        sh_q <= '1;
                     end else begin
                        bidx_q <= bidx_q + 1'b1;
                        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q == TX_SEND);
   assign txd_o  = (st_q == TX_SEND) ? sh_q[0] : 1'b1;

endmodule

// File: rtl/mwu_node.sv
module mwu_node #(
   parameter int unsigned OVS         = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick_i,
   input  logic              rxd_i,
   input  logic [DATA_W-1:0] own_code_i,
   input  logic              rearm_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_bit9_o,
   output logic              rx_irq_o,
   output logic              frame_err_o,
   output logic              wake_o,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_start_i,
   output logic              tx_busy_o,
   output logic              txd_o
);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("mwu_node: OVS must be even and at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("mwu_node: DATA_W must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("mwu_node: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_bit9;
   logic              fr_stop_ok;

   mwu_rx_deframe #(
      .OVS         (OVS),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (os_tick_i),
      .rxd_i     (rxd_i),
      .done_o    (fr_done),
      .data_o    (fr_data),
      .bit9_o    (fr_bit9),
      .stop_ok_o (fr_stop_ok)
   );

   mwu_wake_filter #(
      .DATA_W (DATA_W)
   ) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (fr_done),
      .data_i    (fr_data),
      .bit9_i    (fr_bit9),
      .stop_ok_i (fr_stop_ok),
      .own_i     (own_code_i),
      .rearm_i   (rearm_i),
      .wake_o    (wake_o),
      .irq_o     (rx_irq_o),
      .ferr_o    (frame_err_o),
      .data_o    (rx_data_o),
      .bit9_o    (rx_bit9_o)
   );

   mwu_tx #(
      .OVS    (OVS),
      .DATA_W (DATA_W)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (os_tick_i),
      .data_i  (tx_data_i),
      .start_i (tx_start_i),
      .busy_o  (tx_busy_o),
      .txd_o   (txd_o)
   );

endmodule

// File: rtl/mwu_node_chk.sv
module mwu_node_chk (
   input logic clk,
   input logic rst_n,
   input logic rearm_i,
   input logic rx_irq_o,
   input logic frame_err_o,
   input logic rx_bit9_o,
   input logic wake_o,
   input logic tx_start_i,
   input logic tx_busy_o,
   input logic txd_o
);

   a_r13_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_o |=> !rx_irq_o);

   a_r13_ferr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o);

   a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_irq_o && frame_err_o));

   a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_i |=> wake_o);

   a_r3_armed_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq_o && !rx_bit9_o) |-> $past(!wake_o));

   a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq_o && rx_bit9_o && !$past(rearm_i)) |-> !wake_o);

   a_r8_ferr_keeps_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err_o && !$past(rearm_i)) |-> (wake_o == $past(wake_o)));

   a_r11_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy_o |-> txd_o);

   a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start_i && tx_busy_o) |=> tx_busy_o);

endmodule

bind mwu_node mwu_node_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rearm_i     (rearm_i),
   .rx_irq_o    (rx_irq_o),
   .frame_err_o (frame_err_o),
   .rx_bit9_o   (rx_bit9_o),
   .wake_o      (wake_o),
   .tx_start_i  (tx_start_i),
   .tx_busy_o   (tx_busy_o),
   .txd_o       (txd_o)
);

// File: tb/tb_mwu_node.sv
`timescale 1ns/1ps
module tb_mwu_node;

   localparam int BIT_CLKS = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rxd_b = 1'b1;
   logic       loop = 1'b0;
   logic [7:0] own = 8'h5A;
   logic       rearm = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9, rx_irq, ferr, wake;
   logic [7:0] tx_data = 8'h00;
   logic       tx_start = 1'b0;
   logic       tx_busy, txd;
   logic       rxd_w;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   int ferr_cnt = 0;
   int dbl_cnt = 0;
   logic       irq_prev = 1'b0;
   logic [7:0] cap_data = 8'h00;
   logic       cap_b9 = 1'b0;
   bit         model_wake = 1'b1;
   bit         done = 1'b0;

   assign rxd_w = loop ? txd : rxd_b;

   always #4 clk = ~clk;

   mwu_node dut (
      .clk(clk), .rst_n(rst_n), .os_tick_i(tick), .rxd_i(rxd_w),
      .own_code_i(own), .rearm_i(rearm), .rx_data_o(rx_data),
      .rx_bit9_o(rx_bit9), .rx_irq_o(rx_irq), .frame_err_o(ferr),
      .wake_o(wake), .tx_data_i(tx_data), .tx_start_i(tx_start),
      .tx_busy_o(tx_busy), .txd_o(txd)
   );

   always @(negedge clk) begin
      tick <= ~tick;
      if (rx_irq) begin
         irq_cnt  <= irq_cnt + 1;
         cap_data <= rx_data;
         cap_b9   <= rx_bit9;
      end
      if (ferr) ferr_cnt <= ferr_cnt + 1;
      if ((rx_irq && irq_prev) || (rx_irq && ferr)) dbl_cnt <= dbl_cnt + 1;
      irq_prev <= rx_irq;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_irq(bit w, bit b9, logic [7:0] d, logic [7:0] o, bit sok);
      if (!sok) return 1'b0;
      if (b9) return (d == o);
      return !w;
   endfunction

   function automatic bit next_wake(bit w, bit b9, logic [7:0] d, logic [7:0] o, bit sok);
      if (!sok) return w;
      if (b9) return (d != o);
      return w;
   endfunction

   task automatic send_frame(input logic [7:0] d, input bit b9, input bit sok);
      logic [10:0] f;
      f = {sok, b9, d, 1'b0};
      for (int i = 0; i < 11; i++) begin
         rxd_b = f[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      rxd_b = 1'b1;
      repeat (2 * BIT_CLKS) @(negedge clk);
   endtask

   task automatic frame_check(input logic [7:0] d, input bit b9, input bit sok, input string tag);
      int  i0, f0;
      bit  e;
      i0 = irq_cnt;
      f0 = ferr_cnt;
      e  = exp_irq(model_wake, b9, d, own, sok);
      send_frame(d, b9, sok);
      model_wake = next_wake(model_wake, b9, d, own, sok);
      chk((irq_cnt - i0) == int'(e), {tag, " irq count"}, irq_cnt - i0, int'(e));
      if (e) begin
         chk(cap_data == d, {tag, " R1 data"}, cap_data, d);
         chk(cap_b9 == b9, {tag, " R1 ninth bit"}, cap_b9, b9);
      end
      chk((ferr_cnt - f0) == int'(!sok), {tag, " R8 ferr count"}, ferr_cnt - f0, int'(!sok));
      chk(wake == model_wake, {tag, " wake"}, wake, model_wake);
   endtask

   task automatic do_rearm();
      rearm = 1'b1;
      @(negedge clk);
      rearm = 1'b0;
      model_wake = 1'b1;
      chk(wake == 1'b1, "R10 rearm sets wake", wake, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int i0;
      void'($urandom(32'd4417));
      repeat (5) @(negedge clk);
      // R2 reset state
      chk(wake == 1'b1, "R2 wake after reset", wake, 1);
      chk(rx_irq == 1'b0 && ferr == 1'b0, "R2 pulses low", {rx_irq, ferr}, 0);
      chk(tx_busy == 1'b0 && txd == 1'b1, "R2 tx idle", {tx_busy, txd}, 1);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      frame_check(8'h33, 1'b0, 1'b1, "R3 data while armed");
      frame_check(8'h5A, 1'b1, 1'b1, "R4 matching address");
      frame_check(8'hC3, 1'b0, 1'b1, "R5 data while disarmed");
      frame_check(8'h5A, 1'b1, 1'b1, "R7 repeat match");
      frame_check(8'h01, 1'b0, 1'b1, "R5 second data");
      frame_check(8'h80, 1'b0, 1'b0, "R8 bad stop disarmed");
      frame_check(8'hA5, 1'b1, 1'b1, "R6 mismatching address");
      frame_check(8'h77, 1'b0, 1'b1, "R3 data after mismatch");
      frame_check(8'h5A, 1'b1, 1'b0, "R8 bad stop on match");

      // R9 short glitch
      i0 = irq_cnt;
      rxd_b = 1'b0;
      repeat (8) @(negedge clk);
      rxd_b = 1'b1;
      repeat (2 * BIT_CLKS) @(negedge clk);
      chk(irq_cnt == i0 && ferr == 1'b0, "R9 glitch ignored", irq_cnt - i0, 0);
      frame_check(8'h5A, 1'b1, 1'b1, "R9 frame after glitch");
      do_rearm();

      // R11 / R12 loopback of reply
      frame_check(8'h5A, 1'b1, 1'b1, "R4 address before reply");
      loop = 1'b1;
      i0 = irq_cnt;
      tx_data = 8'h96;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      repeat (20) @(negedge clk);
      chk(tx_busy == 1'b1, "R11 busy during frame", tx_busy, 1);
      tx_data = 8'h3C;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      repeat (320) @(negedge clk);
      chk(tx_busy == 1'b1, "R11 busy through stop", tx_busy, 1);
      repeat (60) @(negedge clk);
      chk(tx_busy == 1'b0, "R11 busy ends", tx_busy, 0);
      repeat (2 * BIT_CLKS) @(negedge clk);
      chk(irq_cnt - i0 == 1, "R12 only one reply frame", irq_cnt - i0, 1);
      chk(cap_data == 8'h96, "R11 reply byte order", cap_data, 8'h96);
      chk(cap_b9 == 1'b0, "R11 reply ninth bit zero", cap_b9, 0);
      loop = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);

      // random mix
      for (int n = 0; n < 110; n++) begin
         logic [7:0] d;
         bit b9, sok;
         string tag;
         if ($urandom % 10 == 0) do_rearm();
         if ($urandom % 12 == 0) own = 8'($urandom);
         sok = ($urandom % 8) != 0;
         b9  = $urandom % 2;
         d   = (b9 && ($urandom % 2 == 1)) ? own : 8'($urandom);
         if (!sok)               tag = "R8 random bad stop";
         else if (b9 && d == own) tag = model_wake ? "R4 random match" : "R7 random match";
         else if (b9)            tag = "R6 random mismatch";
         else                    tag = model_wake ? "R3 random armed data" : "R5 random data";
         frame_check(d, b9, sok, tag);
      end

      chk(dbl_cnt == 0, "R13 single pulses", dbl_cnt, 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule